// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire PHY management link. A host loads a 16-bit payload and a command byte through a small byte-wide register file. It then supplies a PHY address and an operation select, and pulses a start strobe. The block generates the management clock and serializes a complete frame onto a shared data line. On a read, it releases that line at turnaround, shifts in the PHY's answer and writes the answer back into the payload registers.

The management clock period can be changed at run time. A 3-bit field in the command byte stretches each half period to that field plus one system clocks. The clock rests low between frames, and the data line is left undriven. Each frame is 32 preamble ones followed by the 32-bit addressed word. The host watches a busy level and a one-cycle done pulse.

Top module: `mdio_master`

## Requirements
- R1: After reset both payload registers read 0, the command byte reads 8'h20 (period field 1, register address 0), and busy, done, mdc and mdio_oe are all 0.
- R2: While a frame runs, mdc is high for exactly per+1 system clocks in each cycle and has a period of 2*(per+1). Here per is the period field latched at the accepted start.
- R3: Sampled at each rising mdc edge, the 64 bits of a frame are as follows. Bits 0..31 are ones. Bits 32..33 are 0,1. Bits 34..35 are the opcode: 0,1 for a write and 1,0 for a read. Bits 36..40 are the PHY address, MSB first. Bits 41..45 are the register address, MSB first, so its LSB is bit 45. Bits 46..47 are turnaround, and bits 48..63 are data.
- R4: On a write, mdio_oe is 1 for all 64 bits and turnaround is driven as 1 then 0. Data bit 48 is bit 7 of the upper payload register, and bit 63 is bit 0 of the lower one.
- R5: On a read, mdio_oe is 0 from bit 46 to the end of the frame. The value of mdio_i at each rising mdc edge of bits 48..63 is captured MSB first: the first 8 go to the upper payload register and the last 8 to the lower one, written when the frame ends.
- R6: mdio_o changes only while mdc is low.
- R7: busy is 1 for exactly 128*(per+1) system clocks, starting the clock after the accepted start. done is a single-cycle pulse in the cycle busy falls.
- R8: A start while busy is ignored: the frame under way keeps its bits and length, and no further frame follows it. Host writes to the command byte during a frame have no effect on that frame.
- R9: While not busy, mdc and mdio_oe are 0.
- R10: Register map on reg_addr: 0 is the lower payload byte, 1 the upper payload byte, 2 the command byte {period[7:5], register address[4:0]}, and 3 reads 0. reg_rdata shows the addressed register one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write enable |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Registered host read data |
| phy_addr | input | 5 | PHY address for the next frame |
| op_read | input | 1 | 1 selects a read frame, 0 a write frame |
| start | input | 1 | Start strobe, accepted only when idle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line input from the pad |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
Frames are run with the period field at 0, 1, 2, 3 and 7, so an off-by-one in the divider shows up as a wrong high time and a wrong busy length. Write payloads with a single bit set at each end tell a reversed bit order apart from a correct one. All-ones and all-zero addresses expose field misplacement. Read responses with asymmetric patterns such as 16'h0001 and 16'hFFFE show a swap of the two payload bytes or a one-bit slip in capture. A start strobe and a command-byte write injected mid-frame separate a master that latches its settings from one that follows the live registers.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [1:0] FR_START = 2'b01;
  localparam logic [1:0] FR_OP_WR = 2'b01;
  localparam logic [1:0] FR_OP_RD = 2'b10;
  localparam logic [1:0] FR_TA_WR = 2'b10;

  typedef enum logic [1:0] {
    SEL_DLO = 2'd0,
    SEL_DHI = 2'd1,
    SEL_CMD = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PER_W-1:0] per,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [PER_W-1:0] cnt;
  logic             tick;

  assign tick     = run && (cnt == per);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: the clock rests low whenever no frame runs
  a_r9_mdc_rests_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              cap_en,
  output logic [DATA_W-1:0] cap_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int FRAME_W = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TOTAL   = PRE_LEN + FRAME_W;
  localparam int CNT_W   = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] TA_C   = CNT_W'(PRE_LEN + 4 + 2 * ADDR_W);
  localparam logic [CNT_W-1:0] DAT_C  = CNT_W'(PRE_LEN + 6 + 2 * ADDR_W);

  logic [CNT_W-1:0]   bitcnt;
  logic [CNT_W-1:0]   nxt;
  logic [FRAME_W-1:0] word_sh;
  logic [DATA_W-1:0]  rd_sh;
  logic               rd_q;

  assign nxt      = bitcnt + 1'b1;
  assign cap_data = rd_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cap_en  <= 1'b0;
      bitcnt  <= '0;
      word_sh <= '0;
      rd_sh   <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done   <= 1'b0;
      cap_en <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy    <= 1'b1;
          bitcnt  <= '0;
          word_sh <= {FR_START, (is_read ? FR_OP_RD : FR_OP_WR), phy, regad, FR_TA_WR, wdata};
          rd_q    <= is_read;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b1;
        end
      end else begin
        if (rise_evt && rd_q && (bitcnt >= DAT_C))
          rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
        if (fall_evt) begin
          if (bitcnt == LAST_C) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            cap_en  <= rd_q;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            bitcnt <= nxt;
            if (nxt < PRE_C) begin
              mdio_o <= 1'b1;
            end else begin
              mdio_o  <= word_sh[FRAME_W-1];
              word_sh <= {word_sh[FRAME_W-2:0], 1'b0};
            end
            mdio_oe <= !(rd_q && (nxt >= TA_C));
          end
        end
      end
    end
  end

  // R5: line stays released once a read has reached turnaround
  a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
    busy && rd_q && (bitcnt >= TA_C) |-> !mdio_oe);
  // R4: a write drives the line for its whole length
  a_r4_write_driven: assert property (@(posedge clk) disable iff (rst)
    busy && !rd_q |-> mdio_oe);
  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PER_W   = 3,
  parameter int ADDR_W  = 5,
  parameter int BYTE_W  = 8,
  parameter int PRE_LEN = 32,
  parameter int PER_RST = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              op_read,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] data_lo, data_hi;
  logic [PER_W-1:0]  per_f, per_q;
  logic [ADDR_W-1:0] regad_f;
  logic              go, rise_evt, fall_evt, cap_en;
  logic [DATA_W-1:0] cap_data;
  reg_sel_t          sel;

  assign go  = start && !busy;
  assign sel = reg_sel_t'(reg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_lo <= '0;
      data_hi <= '0;
      per_f   <= PER_W'(PER_RST);
      regad_f <= '0;
    end else if (cap_en) begin
      data_hi <= cap_data[DATA_W-1:BYTE_W];
      data_lo <= cap_data[BYTE_W-1:0];
    end else if (reg_we) begin
      case (sel)
        SEL_DLO: data_lo <= reg_wdata;
        SEL_DHI: data_hi <= reg_wdata;
        SEL_CMD: begin
          per_f   <= reg_wdata[BYTE_W-1 -: PER_W];
          regad_f <= reg_wdata[ADDR_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) per_q <= PER_W'(PER_RST);
    else if (go) per_q <= per_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (sel)
        SEL_DLO: reg_rdata <= data_lo;
        SEL_DHI: reg_rdata <= data_hi;
        SEL_CMD: reg_rdata <= {per_f, regad_f};
        default: reg_rdata <= '0;
      endcase
    end
  end

  mdio_mdc_gen #(.PER_W(PER_W)) u_mdc (
    .clk(clk), .rst(rst), .run(busy), .per(per_q),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .go(go), .is_read(op_read), .phy(phy_addr),
    .regad(regad_f), .wdata({data_hi, data_lo}), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .mdio_i(mdio_i), .busy(busy), .done(done),
    .cap_en(cap_en), .cap_data(cap_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R6: data only moves while the clock is low
  a_r6_change_on_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);
  // R9: idle means released line
  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe && !mdc);
  // R7: every end of frame is flagged
  a_r7_fall_has_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R8: a start during a frame leaves the latched period alone
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> per_q == $past(per_q));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {read, per[2:0], phy[4:0], regad[4:0], data_or_response[15:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 5'h01, 5'h00, 16'hA55A},
    {1'b0, 3'd7, 5'h1F, 5'h1F, 16'h8001},
    {1'b1, 3'd2, 5'h12, 5'h05, 16'hC3E1},
    {1'b1, 3'd0, 5'h00, 5'h1E, 16'h0001},
    {1'b0, 3'd3, 5'h0A, 5'h15, 16'h0000},
    {1'b1, 3'd1, 5'h15, 5'h0A, 16'hFFFE}
  };

  logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0, op_read = 1'b0, start = 1'b0, mdio_i = 1'b1;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [4:0] phy_addr = '0;
  logic busy, done, mdc, mdio_o, mdio_oe;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .phy_addr(phy_addr), .op_read(op_read), .start(start),
    .busy(busy), .done(done), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] build_word(input bit rd, input logic [4:0] phy,
                                             input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
  endfunction

  task automatic run_frame(input bit rd, input logic [2:0] per, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] val, input bit disturb);
    logic [63:0] got_o, got_oe;
    logic [31:0] w;
    logic [7:0] rb;
    int n, rises, hi_len, bad_bits, r6_viol;
    logic prev_mdc, prev_o;
    w = build_word(rd, phy, ra, val);
    wr_reg(2'd0, rd ? ~val[7:0] : val[7:0]);
    wr_reg(2'd1, rd ? ~val[15:8] : val[15:8]);
    wr_reg(2'd2, {per, ra});
    rd_reg(2'd2, rb);
    chk(rb == {per, ra}, "R10 command byte readback", rb, {per, ra});
    phy_addr = phy; op_read = rd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; rises = 0; hi_len = 0; bad_bits = 0; r6_viol = 0;
    prev_mdc = 1'b0; prev_o = mdio_o; got_o = '0; got_oe = '0;
    while (busy && n < 5000) begin
      n++;
      reg_we = 1'b0; start = 1'b0;
      if (disturb && n == 20) begin
        start = 1'b1; op_read = ~rd;
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'hFF;
      end
      if (mdc && !prev_mdc) begin
        if (rises < 64) begin
          got_o[rises] = mdio_o; got_oe[rises] = mdio_oe;
        end
        rises++;
      end
      if (mdc && rises == 1) hi_len++;
      if (mdc && prev_mdc && mdio_o != prev_o) r6_viol++;
      if (!mdc && prev_mdc) mdio_i = (rises >= 48 && rises < 64) ? val[63-rises] : 1'b1;
      prev_mdc = mdc; prev_o = mdio_o;
      @(negedge clk);
    end
    reg_we = 1'b0; start = 1'b0;
    chk(done == 1'b1, "R7 done at busy fall", done, 1);
    chk(n == 128 * (per + 1), "R7 busy length", n, 128 * (per + 1));
    chk(hi_len == per + 1, "R2 mdc high time", hi_len, per + 1);
    chk(rises == 64, "R2 mdc cycle count", rises, 64);
    chk(r6_viol == 0, "R6 mdio_o change while mdc high", r6_viol, 0);
    for (int i = 0; i < 64; i++) begin
      logic eb, eo;
      eb = (i < 32) ? 1'b1 : w[63-i];
      eo = !(rd && i >= 46);
      if (got_oe[i] != eo) bad_bits++;
      else if (eo && got_o[i] != eb) bad_bits++;
    end
    chk(bad_bits == 0, rd ? "R3 R5 read frame bits" : "R3 R4 write frame bits", bad_bits, 0);
    @(negedge clk);
    chk(done == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle after frame",
        {done, mdc, mdio_oe}, 0);
    if (rd) begin
      rd_reg(2'd1, rb);
      chk(rb == val[15:8], "R5 captured upper byte", rb, val[15:8]);
      rd_reg(2'd0, rb);
      chk(rb == val[7:0], "R5 captured lower byte", rb, val[7:0]);
    end
    mdio_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R10 map
    chk(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1 R9 reset outputs",
        {busy, done, mdc, mdio_oe}, 0);
    rd_reg(2'd0, rb); chk(rb == 8'h00, "R1 lower payload reset", rb, 8'h00);
    rd_reg(2'd1, rb); chk(rb == 8'h00, "R1 upper payload reset", rb, 8'h00);
    rd_reg(2'd2, rb); chk(rb == 8'h20, "R1 command byte reset", rb, 8'h20);
    rd_reg(2'd3, rb); chk(rb == 8'h00, "R10 unused address reads zero", rb, 8'h00);

    for (int v = 0; v < NVEC; v++)
      run_frame(VEC[v][29], VEC[v][28:26], VEC[v][25:21], VEC[v][20:16], VEC[v][15:0], 1'b0);

    // R8: start and command write mid-frame must not alter this frame
    run_frame(1'b0, 3'd0, 5'h05, 5'h03, 16'h1234, 1'b1);
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R8 no frame after ignored start", busy, 0);
    rd_reg(2'd2, rb); chk(rb == 8'hFF, "R8 host command write still lands", rb, 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule